// File: doc/BRIEF.md
# Multi-Criteria Signal Detect Qualifier

This block decides whether a stream of deserialized 10-bit characters is a usable link signal. It receives one character per strobe, a 1-bit amplitude indication from an analog comparator that lives outside the block, and two mode inputs. It produces one registered signal-detect flag.

Time is cut into evaluation windows of a fixed number of accepted characters, eight by default. During a window the block records three kinds of failure:

- the amplitude indication dropped low at any point;
- a character of all zeros or all ones arrived;
- a long special-character timeout ran out without a negative-disparity comma character being seen.

At the last character of the window the enabled criteria are combined. The result drives the flag for the whole of the following window.

The loopback input and the alignment-enable input together pick the checks that take part. A check that the mode leaves out counts as passing. The block only observes the character stream and has no pass-through path, so it cannot disturb the data, the clocks or any comma indication.

Top module: `sigdet_qualifier`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sig_detect` is low after that edge, and the window and timeout counters return to zero.
- R2: A window closes on the accepted character (`char_valid` high) that brings the window count to `WIN_CHARS`. `sig_detect` changes only on the edge that closes a window, and holds its value on every other edge.
- R3: If `amp_ok` is sampled low on any clock edge of a window, idle edges and the closing edge included, the next window's `sig_detect` is low.
- R4: An accepted character equal to 10'h000 makes the next window's `sig_detect` low, unless the mode masks the run check.
- R5: An accepted character equal to 10'h3FF makes the next window's `sig_detect` low, unless the mode masks the run check.
- R6: The qualifying character is 10'h17C. This is 0011111010 with the first-received bit in `char_in[0]`.
  - Each accepted qualifying character restarts the timeout count at zero.
  - The `K_TIMEOUT`-th consecutive accepted non-qualifying character is an expiry. The expiry fails the current window and restarts the count.
  - When the K check is enabled, that failure makes the next window's `sig_detect` low.
- R7: With `loopback`=0 and `align_en`=0, the amplitude, all-zeros, all-ones and timeout checks are all enabled.
- R8: With `loopback`=0 and `align_en`=1, a timeout expiry has no effect on `sig_detect`. The other checks stay enabled.
- R9: With `loopback`=1, whatever the value of `align_en`, only the amplitude check is enabled.
- R10: When every enabled check passes during a window, `sig_detect` is high for the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_valid | input | 1 | Strobe: `char_in` holds a new character |
| char_in | input | 10 | Received character, first-received bit in bit 0 |
| amp_ok | input | 1 | Amplitude indication from the external comparator |
| loopback | input | 1 | Loopback mode select |
| align_en | input | 1 | Alignment-enable mode select |
| sig_detect | output | 1 | Registered signal-detect flag |

## Verification
The assertions assume that `loopback` and `align_en` are steady for each window, because the mode is sampled only on the closing edge. They also assume that `char_in` is meaningful only while `char_valid` is high. The stimulus changes the mode only between windows. It drives filler characters that never equal the all-zeros, all-ones or qualifying codes unless a sweep places them on purpose. It also inserts idle strobe-low cycles, both to show that those cycles do not advance the window and to show that `amp_ok` is still sampled during them.

// File: rtl/sigdet_pkg.sv
// sigdet_pkg: shared constants, mode type and mode-to-check mapping for
// the signal detect qualifier. Assumes 10-bit characters with the
// first-received bit in bit 0.
package sigdet_pkg;

    localparam int CHAR_W = 10;

    // Negative-disparity comma character, first-received bit in bit 0.
    localparam logic [CHAR_W-1:0] K285_NEG  = 10'h17C;
    localparam logic [CHAR_W-1:0] ALL_ZEROS = '0;
    localparam logic [CHAR_W-1:0] ALL_ONES  = '1;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_NOALIGN = 2'd1,
        MODE_LOOP    = 2'd2
    } sd_mode_e;

    typedef struct packed {
        logic amp;   // amplitude check enabled
        logic run;   // all-zeros / all-ones check enabled
        logic kchr;  // qualifying-character timeout enabled
    } sd_enable_t;

    // Map the two mode pins to a mode.
    function automatic sd_mode_e decode_mode(input logic lb, input logic al);
        if (lb)      return MODE_LOOP;
        else if (al) return MODE_NOALIGN;
        else         return MODE_NORMAL;
    endfunction

    // Map a mode to the set of checks that take part.
    function automatic sd_enable_t mode_enables(input sd_mode_e m);
        sd_enable_t e;
        e.amp = 1'b1;
        unique case (m)
            MODE_NORMAL:  begin e.run = 1'b1; e.kchr = 1'b1; end
            MODE_NOALIGN: begin e.run = 1'b1; e.kchr = 1'b0; end
            default:      begin e.run = 1'b0; e.kchr = 1'b0; end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/sd_window_ctr.sv
// sd_window_ctr: counts accepted characters and flags the last character
// of each evaluation window.
// Assumes WIN_CHARS >= 2. Only strobed characters advance the count.
module sd_window_ctr #(
    parameter int WIN_CHARS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_valid,
    output logic win_end
);
    localparam int CW = (WIN_CHARS > 2) ? $clog2(WIN_CHARS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_CHARS - 1);

    logic [CW-1:0] wcnt;

    // The closing character is the strobed one at the last count.
    assign win_end = char_valid && (wcnt == LAST);

    // Advance on each strobe, wrap at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n)          wcnt <= '0;
        else if (win_end)    wcnt <= '0;
        else if (char_valid) wcnt <= wcnt + 1'b1;
    end

    AST_WCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt <= LAST);                                            // R2
    AST_WCNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !char_valid |=> $stable(wcnt));                           // R2

endmodule

// File: rtl/sd_pattern_mon.sv
// sd_pattern_mon: tracks amplitude drop-outs and all-zeros / all-ones
// characters within the current window.
// Assumes amp_ok is sampled on every clock edge and char_in only when
// char_valid is high. The "now" outputs include the current cycle, so
// the closing character is counted in its own window.
module sd_pattern_mon
    import sigdet_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              amp_ok,
    input  logic              win_end,
    output logic              amp_pass_now,
    output logic              run_pass_now
);
    logic amp_bad_q, run_bad_q;
    logic run_hit;

    // A strobed character that is a forbidden run code.
    assign run_hit = char_valid && ((char_in == ALL_ZEROS) || (char_in == ALL_ONES));

    // Pass flags as seen on this cycle, current inputs included.
    always_comb begin
        amp_pass_now = !(amp_bad_q || !amp_ok);
        run_pass_now = !(run_bad_q || run_hit);
    end

    // Sticky failure flags, cleared when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n || win_end) begin
            amp_bad_q <= 1'b0;
            run_bad_q <= 1'b0;
        end else begin
            amp_bad_q <= !amp_pass_now;
            run_bad_q <= !run_pass_now;
        end
    end

    AST_AMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!amp_ok && !win_end) |=> !amp_pass_now);                 // R3
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_hit && !win_end) |=> !run_pass_now);                 // R4

endmodule

// File: rtl/sd_k285_timer.sv
// sd_k285_timer: counts accepted characters since the last qualifying
// comma character and reports an expiry within the current window.
// Assumes TIMEOUT >= 2. The count restarts on every qualifying character
// and also after an expiry.
module sd_k285_timer
    import sigdet_pkg::*;
#(
    parameter int TIMEOUT = 65560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              win_end,
    output logic              k_pass_now
);
    localparam int KW = $clog2(TIMEOUT);
    localparam logic [KW-1:0] KLAST = KW'(TIMEOUT - 1);

    logic [KW-1:0] kcnt;
    logic          miss_q;
    logic          k_hit, expire;

    assign k_hit  = char_valid && (char_in == K285_NEG);
    assign expire = char_valid && !k_hit && (kcnt == KLAST);

    // An expiry on this cycle already fails the window.
    assign k_pass_now = !(miss_q || expire);

    // Characters since the last qualifying one.
    always_ff @(posedge clk) begin
        if (!rst_n)               kcnt <= '0;
        else if (k_hit || expire) kcnt <= '0;
        else if (char_valid)      kcnt <= kcnt + 1'b1;
    end

    // Sticky miss flag for the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || win_end) miss_q <= 1'b0;
        else                   miss_q <= !k_pass_now;
    end

    AST_KCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        kcnt <= KLAST);                                           // R6
    AST_K_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        k_hit |=> (kcnt == '0));                                  // R6

endmodule

// File: rtl/sigdet_qualifier.sv
// sigdet_qualifier: top level. Combines the amplitude, run and
// qualifying-character checks under the selected mode at the close of
// each window, and registers the result for the next window.
// Assumes the mode pins are steady across a window. They are sampled on
// the closing edge.
module sigdet_qualifier
    import sigdet_pkg::*;
#(
    parameter int WIN_CHARS = 8,
    parameter int K_TIMEOUT = 65560
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              amp_ok,
    input  logic              loopback,
    input  logic              align_en,
    output logic              sig_detect
);
    logic       win_end;
    logic       amp_pass_now, run_pass_now, k_pass_now;
    sd_mode_e   mode;
    sd_enable_t en;
    logic       window_ok;

    sd_window_ctr #(.WIN_CHARS(WIN_CHARS)) u_win (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .win_end(win_end)
    );

    sd_pattern_mon u_pat (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
        .amp_ok(amp_ok), .win_end(win_end),
        .amp_pass_now(amp_pass_now), .run_pass_now(run_pass_now)
    );

    sd_k285_timer #(.TIMEOUT(K_TIMEOUT)) u_k (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
        .win_end(win_end), .k_pass_now(k_pass_now)
    );

    // Mode selection and masking: a masked check counts as passing.
    always_comb begin
        mode      = decode_mode(loopback, align_en);
        en        = mode_enables(mode);
        window_ok = (!en.amp  || amp_pass_now) &&
                    (!en.run  || run_pass_now) &&
                    (!en.kchr || k_pass_now);
    end

    // Output register, loaded only when a window closes.
    always_ff @(posedge clk) begin
        if (!rst_n)       sig_detect <= 1'b0;
        else if (win_end) sig_detect <= window_ok;
    end

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> !sig_detect);                                  // R1
    AST_HOLD_MIDWINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(sig_detect));                        // R2
    AST_AMP_FAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !amp_pass_now) |=> !sig_detect);              // R3
    AST_LOOP_AMP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && loopback && amp_pass_now) |=> sig_detect);    // R9
    AST_RUN_FAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && !loopback && !run_pass_now) |=> !sig_detect); // R5

endmodule

// File: tb/tb_sigdet_qualifier.sv
// tb_sigdet_qualifier: sweeps every mode with a failure placed at every
// character position of a window, plus timeout boundaries and idle
// cycles. Expected values come from a per-edge model of the requirements.
module tb_sigdet_qualifier;
    localparam int PERIOD = 10;
    localparam int W      = 8;
    localparam int KT     = 20;
    localparam logic [9:0] KCH = 10'h17C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [9:0] char_in = '0;
    logic       amp_ok = 1'b1;
    logic       loopback = 1'b0;
    logic       align_en = 1'b0;
    logic       sig_detect;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    int m_wc = 0, m_kc = 0;
    bit m_amp_bad = 0, m_run_bad = 0, m_kmiss = 0, m_sd = 0;

    sigdet_qualifier #(.WIN_CHARS(W), .K_TIMEOUT(KT)) dut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
        .amp_ok(amp_ok), .loopback(loopback), .align_en(align_en),
        .sig_detect(sig_detect)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sig_detect=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, let the edge pass, update the model, then check.
    task automatic step(input logic v, input logic [9:0] c, input logic a, input string tag);
        bit run_en, k_en;
        @(negedge clk);
        char_valid = v; char_in = c; amp_ok = a;
        @(posedge clk);
        if (!a) m_amp_bad = 1;
        if (v) begin
            if (c == 10'h000 || c == 10'h3FF) m_run_bad = 1;
            if (c == KCH) m_kc = 0;
            else if (m_kc == KT-1) begin m_kmiss = 1; m_kc = 0; end
            else m_kc++;
            if (m_wc == W-1) begin
                run_en = !loopback;
                k_en   = !loopback && !align_en;
                m_sd = !m_amp_bad && !(run_en && m_run_bad) && !(k_en && m_kmiss);
                m_amp_bad = 0; m_run_bad = 0; m_kmiss = 0; m_wc = 0;
            end else m_wc++;
        end
        #(PERIOD/4);
        check(tag, sig_detect, m_sd);
    endtask

    function automatic logic [9:0] filler(input int i);
        case (i % 4)
            0: return 10'h2AA;
            1: return 10'h155;
            2: return 10'h0F3;
            default: return 10'h30C;
        endcase
    endfunction

    // kind: 0 clean, 1 zero char, 2 ones char, 3 amp low, 4 no qualifier.
    task automatic send_window(input int kind, input int pos, input string tag);
        for (int i = 0; i < W; i++) begin
            logic [9:0] c;
            logic a;
            c = (i == 0 && kind != 4) ? KCH : filler(i);
            a = 1'b1;
            if (i == pos) begin
                if (kind == 1) c = 10'h000;
                if (kind == 2) c = 10'h3FF;
                if (kind == 3) a = 1'b0;
            end
            step(1'b1, c, a, tag);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        #(PERIOD/4);
        check("R1 reset", sig_detect, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R10: clean traffic raises the flag; R2 held mid-window.
        for (int n = 0; n < 3; n++) send_window(0, 0, "R10/R2 clean");

        for (int m = 0; m < 4; m++) begin
            string mt;
            loopback = m[1]; align_en = m[0];
            mt = (m == 0) ? "R7" : (m == 1) ? "R8" : "R9";
            send_window(0, 0, {mt, " settle"});
            send_window(0, 0, {mt, " settle"});
            for (int p = 0; p < W; p++) begin
                send_window(1, p, {"R4 ", mt});
                send_window(0, 0, {"R10 ", mt});
                send_window(2, p, {"R5 ", mt});
                send_window(0, 0, {"R10 ", mt});
                send_window(3, p, {"R3 ", mt});
                send_window(0, 0, {"R10 ", mt});
            end
            // Starve the qualifier for three windows (24 > KT chars).
            for (int n = 0; n < 3; n++) send_window(4, 0, {"R6 ", mt});
            for (int n = 0; n < 2; n++) send_window(0, 0, {"R10 ", mt});
            // Idle cycles: R2 count frozen; R3 amp sampled while idle.
            send_window(0, 0, {"R2 ", mt});
            step(1'b0, 10'h000, 1'b1, {"R2 idle ", mt});
            step(1'b0, 10'h3FF, 1'b0, {"R3 idle ", mt});
            send_window(0, 0, {"R3 ", mt});
            send_window(0, 0, {"R10 ", mt});
        end

        // R6 boundary in normal mode: KT-1 fillers between qualifiers pass,
        // KT fillers expire.
        loopback = 1'b0; align_en = 1'b0;
        send_window(0, 0, "R6 sync");
        send_window(0, 0, "R6 sync");
        for (int r = 0; r < 4; r++) begin
            step(1'b1, KCH, 1'b1, "R6 edge");
            for (int i = 0; i < KT - 1 + (r % 2); i++) step(1'b1, filler(i), 1'b1, "R6 edge");
        end
        for (int n = 0; n < 3; n++) send_window(0, 0, "R6 recover");

        // R1 again: mid-run reset clears the flag.
        @(negedge clk); rst_n = 1'b0; char_valid = 1'b0;
        @(posedge clk); #(PERIOD/4);
        check("R1 mid-run reset", sig_detect, 1'b0);
        m_sd = 0; m_wc = 0; m_kc = 0; m_amp_bad = 0; m_run_bad = 0; m_kmiss = 0;
        @(negedge clk); rst_n = 1'b1;
        send_window(0, 0, "R1 post-reset");
        send_window(0, 0, "R10 post-reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule